// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Access Rights

This block caches recent virtual-to-physical page translations for a small address space. A requester presents a 14-bit virtual address with an address-space identifier, a read/write flag and a privilege flag. One clock later the block answers with exactly one of three outcomes: a hit with the 12-bit physical address, a miss, or a protection fault. After a miss the requester walks the page tables itself. It then installs the result through a separate fill port.

The 16 entries form 4 sets of 4 ways. Each entry holds a physical page number and five flags: valid, global, supervisor-only, writable and dirty. An entry marked global is shared by every address space and is never replaced. The rest are tagged with their identifier. A flush input discards every non-global entry in one cycle. A flush-by-identifier variant discards only the non-global entries of one address space.

Top module: `pagemap_tlb`

## Requirements
- R1: On a hit, `rsp_paddr` is the stored 6-bit physical page number in bits 11:6, and the request's `lk_vaddr[5:0]` unchanged in bits 5:0.
- R2: `lk_vaddr[7:6]` selects the set and `lk_vaddr[13:8]` is the tag. The same split applies to `fill_vpn`: bits 1:0 select the set and bits 7:2 are the tag. All 16 entries (4 sets by 4 ways) can be resident at once.
- R3: A lookup that is accepted is answered in the following cycle with `rsp_valid` high and exactly one of `rsp_hit`, `rsp_miss` or `rsp_fault` high. Without an accepted lookup, all four are low. After reset, all four and `fill_reject` are low.
- R4: A lookup that matches no valid entry raises `rsp_miss`. An entry matches when its tag is equal and it is either global or holds the same identifier. If several entries match, the lowest-numbered way wins.
- R5: A non-global entry never matches a lookup that carries a different identifier. A global entry matches under any identifier.
- R6: A matching entry gives `rsp_fault` in two cases: it is supervisor-only and `lk_user`=1, or `lk_write`=1 and it is not writable. A fault leaves the entry's dirty flag unchanged.
- R7: A write hit sets the entry's dirty flag at the edge that registers the response. `rsp_dirty` shows the entry's dirty flag after the access. A read hit leaves the flag as it was. On a miss or a fault, `rsp_dirty` is 0.
- R8: Each set has a round-robin pointer, which reset sets to way 0. A fill takes the first way, starting at the pointer and counting upward modulo 4, that does not hold a valid global entry. The pointer then moves to the way after the victim.
- R9: When all 4 ways of the target set hold valid global entries, the fill is dropped. `fill_reject` is then high for one cycle, in the cycle after the fill, and no entry changes.
- R10: `flush_all` clears the valid flag of every non-global entry in one cycle. Global entries remain.
- R11: `flush_asid_en` clears the valid flag of every non-global entry whose identifier equals `flush_asid`. It leaves all other entries intact.
- R12: When `fill_valid` and `lk_valid` are high in the same cycle, the fill is performed and the lookup is not accepted: no response follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 14 | Virtual address to translate |
| lk_asid | input | 4 | Identifier of the requesting address space |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| fill_valid | input | 1 | Install strobe |
| fill_vpn | input | 8 | Virtual page number to install |
| fill_asid | input | 4 | Identifier stored with the entry |
| fill_ppn | input | 6 | Physical page number stored with the entry |
| fill_global | input | 1 | Entry is shared by all address spaces |
| fill_super | input | 1 | Entry is supervisor-only |
| fill_writable | input | 1 | Entry allows writes |
| fill_dirty | input | 1 | Initial dirty flag |
| flush_all | input | 1 | Invalidate all non-global entries |
| flush_asid_en | input | 1 | Invalidate non-global entries of one identifier |
| flush_asid | input | 4 | Identifier used by the selective flush |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry, access denied |
| rsp_paddr | output | 12 | Physical address on a hit, 0 otherwise |
| rsp_dirty | output | 1 | Dirty flag of the hit entry after the access |
| fill_reject | output | 1 | Previous fill was dropped because its set holds only global entries |

## Verification
The bench fills every way of every set with distinct page numbers. It then reads back each entry with a different offset, which separates set and tag decoding and offset pass-through from way selection. The same pages are looked up under a foreign identifier, and global pages under arbitrary identifiers, which shows whether the identifier takes part in the match. A full sweep of supervisor and writable flags against user/supervisor reads and writes covers every fault combination and every dirty update. Repeated fills into one set, followed by a set made entirely of global entries, test the round-robin order, the skipping of global ways and fill rejection. Sweeps after each flush variant test selective invalidation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W   = 14;
    parameter int PA_W   = 12;
    parameter int OFF_W  = 6;
    parameter int WAYS   = 4;
    parameter int SETS   = 4;
    parameter int ASID_W = 4;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic              sup;
        logic              wr;
        logic              dirty;
        logic [ASID_W-1:0] asid;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_entry_t [WAYS-1:0] ways_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  logic [ASID_W-1:0]     asid_i,
    output logic                  hit_o,
    output logic [WAY_W-1:0]      way_o
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = ways_i[w].valid && (ways_i[w].tag == tag_i) &&
                          (ways_i[w].glob || (ways_i[w].asid == asid_i));
    end

    always_comb begin
        hit_o = |match;
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]  locked_i,
    input  logic [WAY_W-1:0] ptr_i,
    output logic             found_o,
    output logic [WAY_W-1:0] way_o
);
    always_comb begin
        logic [WAY_W-1:0] cand;
        found_o = 1'b0;
        way_o   = ptr_i;
        cand    = ptr_i;
        for (int i = WAYS - 1; i >= 0; i--) begin
            cand = ptr_i + WAY_W'(i);
            if (!locked_i[cand]) begin
                found_o = 1'b1;
                way_o   = cand;
            end
        end
    end
endmodule

// File: rtl/pagemap_tlb.sv
module pagemap_tlb
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_global,
    input  logic              fill_super,
    input  logic              fill_writable,
    input  logic              fill_dirty,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_dirty,
    output logic              fill_reject
);
    typedef struct packed {
        tlb_entry_t [SETS-1:0][WAYS-1:0] ent;
        logic [SETS-1:0][WAY_W-1:0]      rr;
        logic                            rsp_valid;
        logic                            rsp_hit;
        logic                            rsp_miss;
        logic                            rsp_fault;
        logic [PA_W-1:0]                 rsp_paddr;
        logic                            rsp_dirty;
        logic                            fill_rej;
    } state_t;

    state_t d, q;

    // Address split
    logic [IDX_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    assign lk_set = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr[OFF_W+IDX_W +: TAG_W];
    assign fl_set = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

    // Lookup compare
    logic             m_hit;
    logic [WAY_W-1:0] m_way;
    tlb_match u_match (
        .ways_i (q.ent[lk_set]),
        .tag_i  (lk_tag),
        .asid_i (lk_asid),
        .hit_o  (m_hit),
        .way_o  (m_way)
    );

    // Victim choice
    tlb_entry_t [WAYS-1:0] fl_ways;
    logic [WAYS-1:0]       locked;
    logic                  v_found;
    logic [WAY_W-1:0]      v_way;
    assign fl_ways = q.ent[fl_set];
    for (genvar w = 0; w < WAYS; w++) begin : g_lock
        assign locked[w] = fl_ways[w].valid && fl_ways[w].glob;
    end

    tlb_victim u_victim (
        .locked_i (locked),
        .ptr_i    (q.rr[fl_set]),
        .found_o  (v_found),
        .way_o    (v_way)
    );

    tlb_entry_t hit_ent;
    logic       deny;
    assign hit_ent = q.ent[lk_set][m_way];
    assign deny    = (hit_ent.sup && lk_user) || (lk_write && !hit_ent.wr);

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_hit   = 1'b0;
        d.rsp_miss  = 1'b0;
        d.rsp_fault = 1'b0;
        d.rsp_paddr = '0;
        d.rsp_dirty = 1'b0;
        d.fill_rej  = 1'b0;

        // Lookup, only when no fill competes
        if (lk_valid && !fill_valid) begin
            d.rsp_valid = 1'b1;
            if (!m_hit) begin
                d.rsp_miss = 1'b1;
            end else if (deny) begin
                d.rsp_fault = 1'b1;
            end else begin
                d.rsp_hit   = 1'b1;
                d.rsp_paddr = {hit_ent.ppn, lk_vaddr[OFF_W-1:0]};
                d.rsp_dirty = hit_ent.dirty | lk_write;
                if (lk_write) d.ent[lk_set][m_way].dirty = 1'b1;
            end
        end

        // Invalidation of non-global entries
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (q.ent[s][w].valid && !q.ent[s][w].glob &&
                    (flush_all || (flush_asid_en && (q.ent[s][w].asid == flush_asid))))
                    d.ent[s][w].valid = 1'b0;
            end
        end

        // Install
        if (fill_valid) begin
            if (!v_found) begin
                d.fill_rej = 1'b1;
            end else begin
                d.ent[fl_set][v_way].valid = 1'b1;
                d.ent[fl_set][v_way].glob  = fill_global;
                d.ent[fl_set][v_way].sup   = fill_super;
                d.ent[fl_set][v_way].wr    = fill_writable;
                d.ent[fl_set][v_way].dirty = fill_dirty;
                d.ent[fl_set][v_way].asid  = fill_asid;
                d.ent[fl_set][v_way].tag   = fl_tag;
                d.ent[fl_set][v_way].ppn   = fill_ppn;
                d.rr[fl_set]               = v_way + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid   = q.rsp_valid;
    assign rsp_hit     = q.rsp_hit;
    assign rsp_miss    = q.rsp_miss;
    assign rsp_fault   = q.rsp_fault;
    assign rsp_paddr   = q.rsp_paddr;
    assign rsp_dirty   = q.rsp_dirty;
    assign fill_reject = q.fill_rej;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_write,
    input logic            fill_valid,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_dirty,
    input logic            fill_reject
);
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    a_r3_resp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));

    a_r12_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_valid) |-> !rsp_valid);

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    a_r7_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(lk_write)) |-> rsp_dirty);

    a_r9_reject_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_reject |-> $past(fill_valid));
endmodule

bind pagemap_tlb tlb_checker u_tlb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_vaddr    (lk_vaddr),
    .lk_write    (lk_write),
    .fill_valid  (fill_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .rsp_dirty   (rsp_dirty),
    .fill_reject (fill_reject)
);

// File: tb/pagemap_tlb_bench.sv
`timescale 1ns/1ps
module pagemap_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [13:0] lk_vaddr;
    logic [3:0]  lk_asid;
    logic        lk_write, lk_user;
    logic        fill_valid;
    logic [7:0]  fill_vpn;
    logic [3:0]  fill_asid;
    logic [5:0]  fill_ppn;
    logic        fill_global, fill_super, fill_writable, fill_dirty;
    logic        flush_all, flush_asid_en;
    logic [3:0]  flush_asid;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, fill_reject;
    logic [11:0] rsp_paddr;

    always #2.5 clk = ~clk;

    pagemap_tlb u_pagemap_tlb (.*);

    int n_chk = 0;
    int n_bad = 0;

    // Expected-state model
    bit       mv [4][4];
    bit       mg [4][4];
    bit       ms [4][4];
    bit       mw [4][4];
    bit       md [4][4];
    bit [3:0] ma [4][4];
    bit [5:0] mt [4][4];
    bit [5:0] mp [4][4];
    int       mrr [4];

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 4; s++) begin
            mrr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                mv[s][w] = 0; mg[s][w] = 0; ms[s][w] = 0; mw[s][w] = 0;
                md[s][w] = 0; ma[s][w] = 0; mt[s][w] = 0; mp[s][w] = 0;
            end
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_vaddr = '0; lk_asid = '0; lk_write = 0; lk_user = 0;
        fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0;
        fill_global = 0; fill_super = 0; fill_writable = 0; fill_dirty = 0;
        flush_all = 0; flush_asid_en = 0; flush_asid = '0;
    endtask

    // kind: 0 miss, 1 hit, 2 fault
    task automatic lookup(input bit [13:0] va, input bit [3:0] asid, input bit wr,
                          input bit usr, input string rq);
        int s, hw, kind, epa, edt;
        s  = int'(va[7:6]);
        hw = -1;
        for (int w = 3; w >= 0; w--)
            if (mv[s][w] && mt[s][w] == va[13:8] && (mg[s][w] || ma[s][w] == asid)) hw = w;
        kind = 0; epa = 0; edt = 0;
        if (hw >= 0) begin
            if ((ms[s][hw] && usr) || (wr && !mw[s][hw])) kind = 2;
            else begin
                kind = 1;
                epa  = int'(mp[s][hw]) * 64 + int'(va[5:0]);
                edt  = int'(md[s][hw] | wr);
            end
        end
        lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_write = wr; lk_user = usr;
        @(negedge clk);
        chk(rsp_valid == 1, rq, "rsp_valid", int'(rsp_valid), 1);
        chk(rsp_hit == (kind == 1) && rsp_miss == (kind == 0) && rsp_fault == (kind == 2),
            rq, "outcome{hit,miss,fault}", int'({rsp_hit, rsp_miss, rsp_fault}),
            (kind == 1) ? 4 : (kind == 0) ? 2 : 1);
        if (kind == 1) begin
            chk(int'(rsp_paddr) == epa, rq, "rsp_paddr", int'(rsp_paddr), epa);
            chk(int'(rsp_dirty) == edt, rq, "rsp_dirty", int'(rsp_dirty), edt);
            if (wr) md[s][hw] = 1;
        end
        lk_valid = 0; lk_write = 0; lk_user = 0;
    endtask

    function automatic int model_fill(input bit [7:0] vpn, input bit [3:0] asid, input bit [5:0] ppn,
                                      input bit g, input bit su, input bit wr, input bit dt);
        int s, v;
        s = int'(vpn[1:0]);
        v = -1;
        for (int i = 3; i >= 0; i--) begin
            int c;
            c = (mrr[s] + i) % 4;
            if (!(mv[s][c] && mg[s][c])) v = c;
        end
        if (v >= 0) begin
            mv[s][v] = 1; mg[s][v] = g; ms[s][v] = su; mw[s][v] = wr; md[s][v] = dt;
            ma[s][v] = asid; mt[s][v] = vpn[7:2]; mp[s][v] = ppn;
            mrr[s] = (v + 1) % 4;
        end
        return (v < 0) ? 1 : 0;
    endfunction

    task automatic drive_fill(input bit [7:0] vpn, input bit [3:0] asid, input bit [5:0] ppn,
                              input bit g, input bit su, input bit wr, input bit dt);
        fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn;
        fill_global = g; fill_super = su; fill_writable = wr; fill_dirty = dt;
    endtask

    task automatic fill(input bit [7:0] vpn, input bit [3:0] asid, input bit [5:0] ppn,
                        input bit g, input bit su, input bit wr, input bit dt, input string rq);
        int rej;
        rej = model_fill(vpn, asid, ppn, g, su, wr, dt);
        drive_fill(vpn, asid, ppn, g, su, wr, dt);
        @(negedge clk);
        chk(int'(fill_reject) == rej, rq, "fill_reject", int'(fill_reject), rej);
        fill_valid = 0;
    endtask

    task automatic sweep_model(input bit [3:0] asid_override, input bit use_override, input string rq);
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                bit [13:0] va;
                va = {mt[s][w], 2'(s), 6'((s * 11 + w * 17) % 64)};
                lookup(va, use_override ? asid_override : ma[s][w], 0, 0, rq);
            end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        model_reset();
        rst_n = 0;
        repeat (4) @(negedge clk);
        // R3: reset state
        chk(rsp_valid == 0 && rsp_hit == 0 && rsp_miss == 0 && rsp_fault == 0, "R3", "reset rsp", int'(rsp_valid), 0);
        chk(fill_reject == 0, "R3", "reset fill_reject", int'(fill_reject), 0);
        rst_n = 1;
        @(negedge clk);

        // R4: empty table misses everywhere
        for (int s = 0; s < 4; s++) lookup({6'(s * 9), 2'(s), 6'(s)}, 4'd1, 0, 0, "R4");

        // R2, R1: fill all 16 entries and read each back
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++)
                fill({6'(s * 4 + w + 1), 2'(s)}, 4'd1, 6'((s * 4 + w) * 5 + 3), 0, 0, 1, 0, "R2");
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++)
                lookup({6'(s * 4 + w + 1), 2'(s), 6'((s * 13 + w * 7) % 64)}, 4'd1, 0, 0, "R1");
        // R5: foreign identifier misses
        sweep_model(4'd2, 1, "R5");
        // R12 idle: no response without a lookup
        @(negedge clk);
        chk(rsp_valid == 0, "R3", "idle rsp_valid", int'(rsp_valid), 0);

        // R8: round-robin replacement in set 1
        fill({6'd40, 2'd1}, 4'd1, 6'd33, 0, 0, 1, 0, "R8");
        lookup({6'd5, 2'd1, 6'd9}, 4'd1, 0, 0, "R8");
        lookup({6'd40, 2'd1, 6'd9}, 4'd1, 0, 0, "R8");
        fill({6'd41, 2'd1}, 4'd1, 6'd34, 0, 0, 1, 0, "R8");
        lookup({6'd6, 2'd1, 6'd1}, 4'd1, 0, 0, "R8");
        lookup({6'd7, 2'd1, 6'd1}, 4'd1, 0, 0, "R8");

        // R6, R7: all permission combinations in set 3
        for (int c = 0; c < 4; c++)
            fill({6'(50 + c), 2'd3}, 4'd4, 6'(20 + c), 0, c[1], c[0], 0, "R6");
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 4; a++)
                lookup({6'(50 + c), 2'd3, 6'(a * 5 + c)}, 4'd4, a[0], a[1], "R6");
        for (int c = 0; c < 4; c++)
            lookup({6'(50 + c), 2'd3, 6'd63}, 4'd4, 0, 0, "R7");

        // R5, R9: set 2 made entirely global
        for (int w = 0; w < 4; w++)
            fill({6'(60 + w), 2'd2}, 4'd5, 6'(40 + w), 1, 0, 1, 0, "R9");
        for (int w = 0; w < 4; w++)
            lookup({6'(60 + w), 2'd2, 6'(w)}, 4'(9 + w), 0, 0, "R5");
        fill({6'd30, 2'd2}, 4'd1, 6'd7, 0, 0, 1, 0, "R9");
        @(negedge clk);
        chk(fill_reject == 0, "R9", "reject one cycle", int'(fill_reject), 0);
        lookup({6'd30, 2'd2, 6'd0}, 4'd1, 0, 0, "R9");
        sweep_model(4'd0, 0, "R9");

        // R11: flush by identifier
        fill({6'd20, 2'd0}, 4'd6, 6'd50, 0, 0, 1, 0, "R11");
        fill({6'd21, 2'd0}, 4'd6, 6'd51, 0, 0, 1, 0, "R11");
        lookup({6'd20, 2'd0, 6'd2}, 4'd6, 0, 0, "R11");
        flush_asid_en = 1; flush_asid = 4'd6;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++)
                if (!mg[s][w] && ma[s][w] == 4'd6) mv[s][w] = 0;
        @(negedge clk);
        flush_asid_en = 0;
        lookup({6'd20, 2'd0, 6'd2}, 4'd6, 0, 0, "R11");
        lookup({6'd21, 2'd0, 6'd2}, 4'd6, 0, 0, "R11");
        sweep_model(4'd0, 0, "R11");

        // R10: flush everything non-global
        flush_all = 1;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++)
                if (!mg[s][w]) mv[s][w] = 0;
        @(negedge clk);
        flush_all = 0;
        sweep_model(4'd0, 0, "R10");
        lookup({6'd61, 2'd2, 6'd8}, 4'd15, 0, 0, "R10");

        // R12: fill and lookup in the same cycle
        void'(model_fill({6'd12, 2'd1}, 4'd3, 6'd17, 0, 0, 0, 1));
        drive_fill({6'd12, 2'd1}, 4'd3, 6'd17, 0, 0, 0, 1);
        lk_valid = 1; lk_vaddr = {6'd60, 2'd2, 6'd4}; lk_asid = 4'd3;
        @(negedge clk);
        chk(rsp_valid == 0, "R12", "rsp_valid with fill", int'(rsp_valid), 0);
        fill_valid = 0; lk_valid = 0;
        @(negedge clk);
        chk(rsp_valid == 0, "R12", "no late response", int'(rsp_valid), 0);
        lookup({6'd12, 2'd1, 6'd33}, 4'd3, 0, 0, "R12");
        lookup({6'd12, 2'd1, 6'd33}, 4'd3, 1, 0, "R6");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule